// File: doc/BRIEF.md
# Dual-Rule Cellular Automaton Byte Pattern Generator

This block is an on-chip stimulus source for built-in self test. It holds an 11-cell, two-state additive cellular automaton. Each cell's next value depends only on itself and its two neighbours, and the two cells past the ends of the array read as 0. The block emits one byte of the automaton state per step. A multiplexer on the leftmost cell selects between an XOR rule and an XNOR rule, which gives a normal automaton and its dual. A second multiplexer on the rightmost cell can flip that bit. A small sequencer drives both multiplexers so that the block walks two complementary 16-state cycles in turn.

After `load_i` puts the start state (a build parameter) into the array, a `start_i` pulse launches the traversal. Each outer pass does four things in order. It flips the low bit. It emits a full 16-state dual cycle. It takes one silent normal step. It then emits a full 16-state normal cycle. The traversal stops when the state after a pass equals the state captured at start. With the default start state this happens after 16 passes, so the block emits 32 sequences of 16 bytes and then raises `done_o`. A pass counter stops a start state that never returns, raising `error_o` instead.

Top module: `ca_pattern_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pattern_o`, `valid_o`, `seq_end_o`, `done_o` and `error_o` are all 0.
- R2: In normal mode the leftmost cell (state bit 10) takes the value of its right neighbour. Every other cell takes itself XOR its right neighbour, and the rightmost cell (bit 0) sees a 0 neighbour, so it keeps its value.
- R3: In dual mode the leftmost cell takes the inverse of its right neighbour. All other cells follow the rule of R2.
- R4: Each outer pass runs in this order: flip state bit 0 (no output); emit 16 states while stepping the dual rule; one normal step with no output; emit 16 states while stepping the normal rule.
- R5: `pattern_o` carries state bits 7..0 of the emitted state, bit 0 being the rightmost cell. Emitted bytes appear one cycle after the state is stepped.
- R6: `valid_o` is high exactly for emitted bytes. `seq_end_o` is high together with `valid_o` on every 16th emitted byte and at no other time.
- R7: After a pass, if the state equals the state captured at start, `done_o` goes high and stays high. With the default start state 11'h003 this takes exactly 16 passes and 512 bytes, and `error_o` stays low.
- R8: If LOOP_LIMIT passes complete without a match, `error_o` goes high instead of `done_o` and output stops. A start state 11'h403, which is not on a normal cycle, always ends this way after 512 bytes.
- R9: While the traversal runs, `start_i` and `load_i` have no effect on the output stream.
- R10: When idle, done or in error, `load_i` restores the start state and clears `done_o`/`error_o` on the next cycle, and `start_i` begins a new traversal from the present state. If both are high together, the load wins and no traversal starts. `done_o` holds until one of them arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a traversal from the present state |
| load_i | input | 1 | Restore the start state and return to idle |
| pattern_o | output | 8 | Low byte of the emitted automaton state |
| valid_o | output | 1 | `pattern_o` holds an emitted byte |
| seq_end_o | output | 1 | Last byte of a 16-byte sequence |
| done_o | output | 1 | Traversal returned to its start state |
| error_o | output | 1 | Pass limit reached without return |

## Verification
The assertions assume that `start_i` and `load_i` are only meaningful between traversals. They also assume that the leftmost cell never reaches the emitted byte, so the XOR relation between consecutive bytes of one sequence holds in both modes. The stimulus keeps the traversal correct while pulsing both inputs at random moments during a run, to show they are ignored. It issues its restarts only after `done_o` or `error_o`, including a simultaneous load and start, and its idle gaps have random length from a fixed seed.

// File: rtl/capg_pkg.sv
package capg_pkg;

    localparam int CA_CELLS  = 11;
    localparam int PAT_W     = 8;
    localparam int SEQ_STEPS = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLIP,
        PH_DUAL,
        PH_STEP,
        PH_NORM,
        PH_CHECK,
        PH_DONE,
        PH_HALT
    } phase_t;

    typedef struct packed {
        logic load;
        logic flip;
        logic advance;
        logic dual;
    } ca_cmd_t;

    typedef struct packed {
        logic emit;
        logic last;
    } emit_t;

    function automatic logic rule_inner(input logic self_b, input logic right_b);
        return self_b ^ right_b;
    endfunction

    function automatic logic rule_left(input logic right_b, input logic dual);
        return dual ? ~right_b : right_b;
    endfunction

endpackage

// File: rtl/capg_cell_array.sv
module capg_cell_array
    import capg_pkg::*;
#(
    parameter int               CELLS = CA_CELLS,
    parameter logic [CELLS-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  ca_cmd_t          cmd,
    output logic [CELLS-1:0] state_o
);

    logic [CELLS-1:0] st_q;
    logic [CELLS-1:0] st_d;

    // bit CELLS-1 is the leftmost cell, bit 0 the rightmost
    generate
        for (genvar b = 0; b < CELLS; b++) begin : g_cell
            if (b == CELLS-1) begin : g_left
                assign st_d[b] = cmd.advance ? rule_left(st_q[b-1], cmd.dual) : st_q[b];
            end else if (b == 0) begin : g_right
                assign st_d[b] = cmd.flip    ? ~st_q[b] :
                                 cmd.advance ? rule_inner(st_q[b], 1'b0) : st_q[b];
            end else begin : g_mid
                assign st_d[b] = cmd.advance ? rule_inner(st_q[b], st_q[b-1]) : st_q[b];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || cmd.load) begin
            st_q <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/capg_seq_ctrl.sv
module capg_seq_ctrl
    import capg_pkg::*;
#(
    parameter int CELLS      = CA_CELLS,
    parameter int SEQ_LEN    = SEQ_STEPS,
    parameter int LOOP_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             load_i,
    input  logic [CELLS-1:0] state_i,
    output ca_cmd_t          cmd_o,
    output emit_t            emit_o,
    output logic             done_o,
    output logic             err_o
);

    localparam int CW = $clog2(SEQ_LEN);
    localparam int LW = $clog2(LOOP_LIMIT + 1);
    localparam logic [CW-1:0] CNT_LAST  = CW'(SEQ_LEN - 1);
    localparam logic [LW-1:0] LOOP_LAST = LW'(LOOP_LIMIT);

    phase_t           phase_q;
    logic [CW-1:0]    cnt_q;
    logic [LW-1:0]    loops_q;
    logic [CELLS-1:0] anchor_q;
    logic             at_rest;
    logic             seq_last;

    assign at_rest  = (phase_q == PH_IDLE) || (phase_q == PH_DONE) || (phase_q == PH_HALT);
    assign seq_last = (cnt_q == CNT_LAST);

    always_comb begin
        cmd_o  = '0;
        emit_o = '0;
        unique case (phase_q)
            PH_FLIP: cmd_o.flip = 1'b1;
            PH_DUAL: begin
                cmd_o.advance = 1'b1;
                cmd_o.dual    = 1'b1;
                emit_o.emit   = 1'b1;
                emit_o.last   = seq_last;
            end
            PH_STEP: cmd_o.advance = 1'b1;
            PH_NORM: begin
                cmd_o.advance = 1'b1;
                emit_o.emit   = 1'b1;
                emit_o.last   = seq_last;
            end
            default: cmd_o.load = at_rest & load_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            loops_q  <= '0;
            anchor_q <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_DONE, PH_HALT: begin
                    if (load_i) begin
                        phase_q <= PH_IDLE;
                    end else if (start_i) begin
                        anchor_q <= state_i;
                        loops_q  <= '0;
                        phase_q  <= PH_FLIP;
                    end
                end
                PH_FLIP: begin
                    cnt_q   <= '0;
                    phase_q <= PH_DUAL;
                end
                PH_DUAL: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (seq_last) begin
                        phase_q <= PH_STEP;
                    end
                end
                PH_STEP: begin
                    cnt_q   <= '0;
                    phase_q <= PH_NORM;
                end
                PH_NORM: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (seq_last) begin
                        loops_q <= loops_q + 1'b1;
                        phase_q <= PH_CHECK;
                    end
                end
                PH_CHECK: begin
                    if (state_i == anchor_q) begin
                        phase_q <= PH_DONE;
                    end else if (loops_q >= LOOP_LAST) begin
                        phase_q <= PH_HALT;
                    end else begin
                        phase_q <= PH_FLIP;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done_o = (phase_q == PH_DONE);
    assign err_o  = (phase_q == PH_HALT);

endmodule

// File: rtl/capg_out_stage.sv
module capg_out_stage
    import capg_pkg::*;
#(
    parameter int CELLS = CA_CELLS,
    parameter int PW    = PAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  emit_t            emit_i,
    input  logic [CELLS-1:0] state_i,
    output logic [PW-1:0]    pattern_o,
    output logic             valid_o,
    output logic             seq_end_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pattern_o <= '0;
            valid_o   <= 1'b0;
            seq_end_o <= 1'b0;
        end else begin
            valid_o   <= emit_i.emit;
            seq_end_o <= emit_i.emit & emit_i.last;
            if (emit_i.emit) begin
                pattern_o <= state_i[PW-1:0];
            end
        end
    end

endmodule

// File: rtl/ca_pattern_gen.sv
module ca_pattern_gen
    import capg_pkg::*;
#(
    parameter logic [CA_CELLS-1:0] START_STATE = 11'h003,
    parameter int                  LOOP_LIMIT  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             load_i,
    output logic [PAT_W-1:0] pattern_o,
    output logic             valid_o,
    output logic             seq_end_o,
    output logic             done_o,
    output logic             error_o
);

    ca_cmd_t             cmd;
    emit_t               emit;
    logic [CA_CELLS-1:0] state;

    capg_cell_array #(
        .CELLS (CA_CELLS),
        .INIT  (START_STATE)
    ) u_cells (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .state_o (state)
    );

    capg_seq_ctrl #(
        .CELLS      (CA_CELLS),
        .SEQ_LEN    (SEQ_STEPS),
        .LOOP_LIMIT (LOOP_LIMIT)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_i  (load_i),
        .state_i (state),
        .cmd_o   (cmd),
        .emit_o  (emit),
        .done_o  (done_o),
        .err_o   (error_o)
    );

    capg_out_stage #(
        .CELLS (CA_CELLS),
        .PW    (PAT_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .emit_i    (emit),
        .state_i   (state),
        .pattern_o (pattern_o),
        .valid_o   (valid_o),
        .seq_end_o (seq_end_o)
    );

endmodule

// File: rtl/capg_checker.sv
module capg_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       load_i,
    input logic [7:0] pattern_o,
    input logic       valid_o,
    input logic       seq_end_o,
    input logic       done_o,
    input logic       error_o
);

    AST_SEQEND_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        seq_end_o |-> valid_o); // R6

    AST_RULE_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(seq_end_o)) |->
        (pattern_o[0] == $past(pattern_o[0]) &&
         pattern_o[7:1] == ($past(pattern_o[7:1]) ^ $past(pattern_o[6:0])))); // R2

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_o && error_o)); // R7

    AST_QUIET_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (done_o || error_o) |-> !valid_o); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i && !load_i) |=> done_o); // R10

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((done_o || error_o) && load_i) |=> (!done_o && !error_o)); // R10

endmodule

bind ca_pattern_gen capg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .load_i    (load_i),
    .pattern_o (pattern_o),
    .valid_o   (valid_o),
    .seq_end_o (seq_end_o),
    .done_o    (done_o),
    .error_o   (error_o)
);

// File: tb/sim_ca_pattern_gen.sv
module sim_ca_pattern_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start0 = 1'b0, load0 = 1'b0;
    logic       start1 = 1'b0;
    logic [7:0] pat0, pat1;
    logic       val0, end0, done0, err0;
    logic       val1, end1, done1, err1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int u1_bytes = 0;
    bit collect = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    bit         got_end_q[$];

    always #5 clk = ~clk;

    ca_pattern_gen u0 (
        .clk(clk), .rst(rst), .start_i(start0), .load_i(load0),
        .pattern_o(pat0), .valid_o(val0), .seq_end_o(end0),
        .done_o(done0), .error_o(err0)
    );

    ca_pattern_gen #(.START_STATE(11'h403), .LOOP_LIMIT(16)) u1 (
        .clk(clk), .rst(rst), .start_i(start1), .load_i(1'b0),
        .pattern_o(pat1), .valid_o(val1), .seq_end_o(end1),
        .done_o(done1), .error_o(err1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] step_ca(input logic [10:0] s, input bit dual);
        logic [10:0] n;
        n[10] = dual ? ~s[9] : s[9];
        for (int b = 1; b < 10; b++) n[b] = s[b] ^ s[b-1];
        n[0] = s[0];
        return n;
    endfunction

    task automatic build_expected(input logic [10:0] s0, output int passes, output bit hit);
        logic [10:0] s;
        s = s0;
        passes = 0;
        exp_q.delete();
        do begin
            s[0] = ~s[0];
            for (int k = 0; k < 16; k++) begin
                exp_q.push_back(s[7:0]);
                s = step_ca(s, 1'b1);
            end
            s = step_ca(s, 1'b0);
            for (int k = 0; k < 16; k++) begin
                exp_q.push_back(s[7:0]);
                s = step_ca(s, 1'b0);
            end
            passes++;
        end while (s != s0 && passes < 16);
        hit = (s == s0);
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst && collect && val0) begin
            got_q.push_back(pat0);
            got_end_q.push_back(end0);
        end
        if (!rst && val1) u1_bytes++;
    end

    initial begin : watchdog
        wait (cycles >= 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic run_and_wait(input bit noisy, output bit finished);
        finished = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            start0 = 1'b0;
            load0  = 1'b0;
            if (done0 || err0) begin
                finished = 1'b1;
                break;
            end
            if (noisy && i > 2) begin
                if (($urandom % 13) == 0) start0 = 1'b1;
                if (($urandom % 17) == 0) load0  = 1'b1;
            end
        end
    endtask

    task automatic compare_stream(input string tag);
        check(got_q.size() == exp_q.size(), {"R7 byte count ", tag}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            check(got_q[i] == exp_q[i], {"R2/R3/R4/R5 byte ", tag}, got_q[i], exp_q[i]);
            check(got_end_q[i] == ((i % 16) == 15), {"R6 sequence end ", tag},
                  got_end_q[i], (i % 16) == 15);
        end
    endtask

    initial begin : stim
        int  passes;
        bit  hit;
        bit  fin;
        int  quiet;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        check(pat0 == 8'h00 && !val0 && !end0 && !done0 && !err0, "R1 reset outputs",
              {pat0, val0, end0, done0, err0}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!val0 && !done0 && !err0, "R1 first cycle after reset", {val0, done0, err0}, 0);
        repeat ($urandom_range(1, 9)) @(negedge clk);

        // first traversal, noisy inputs while running
        build_expected(11'h003, passes, hit);
        check(passes == 16 && hit, "R7 model pass count", passes, 16);
        check(exp_q[0] == 8'h02, "R4 first byte has low bit flipped", exp_q[0], 8'h02);
        got_q.delete(); got_end_q.delete();
        collect = 1'b1;
        start0 = 1'b1;
        start1 = 1'b1;
        @(negedge clk);
        start1 = 1'b0;
        run_and_wait(1'b1, fin);
        check(fin, "R7 traversal finishes", fin, 1);
        compare_stream("run1 with noise R9");
        check(done0 && !err0, "R7 done raised", {done0, err0}, 2'b10);

        // error instance
        for (int i = 0; i < 3000 && !err1 && !done1; i++) @(negedge clk);
        check(err1 && !done1, "R8 error raised on non-returning start", {err1, done1}, 2'b10);
        check(u1_bytes == 512, "R8 bytes before error", u1_bytes, 512);
        repeat (3) @(negedge clk);
        check(!val1 && err1, "R8 output stopped", {val1, err1}, 2'b01);

        // done holds
        repeat ($urandom_range(2, 8)) @(negedge clk);
        check(done0, "R10 done holds", done0, 1);

        // restart from done without load
        got_q.delete(); got_end_q.delete();
        start0 = 1'b1;
        run_and_wait(1'b0, fin);
        compare_stream("run2 restart from done R10");

        // load clears done
        load0 = 1'b1;
        @(negedge clk);
        load0 = 1'b0;
        check(!done0 && !err0, "R10 load clears done", done0, 0);

        // simultaneous load and start: load wins
        got_q.delete(); got_end_q.delete();
        load0 = 1'b1; start0 = 1'b1;
        @(negedge clk);
        load0 = 1'b0; start0 = 1'b0;
        quiet = 0;
        repeat (40) begin
            @(negedge clk);
            if (val0) quiet++;
        end
        check(quiet == 0 && got_q.size() == 0, "R10 load beats start", quiet, 0);

        // start after load gives the same stream
        start0 = 1'b1;
        run_and_wait(1'b1, fin);
        compare_stream("run3 after load R10 R9");

        collect = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule